// File: doc/BRIEF.md
# MESI Cache Line Controller

This block is the per-processor side of a directory-based coherence scheme. It keeps a small direct-mapped array of one-word lines. Each line holds a full-address tag, a data word and one of four coherence states. The line index is the low `IDX_W` bits of the address. The processor side issues plain reads and writes. It also issues three transaction requests: eviction, read-shared and read-exclusive. The block either rejects a transaction at once or accepts it, locks the line and places a request on a valid/ready channel toward the directory.

The directory answers over a one-cycle message port. It can send a fill (read response), an eviction acknowledge, a no-op acknowledge, an ownership snoop or a sharer snoop. The ownership snoop returns the line's word one cycle later. A per-line busy flag allows at most one outstanding directory transaction for each line. A directory message always wins the cycle: a processor request presented in that cycle waits, and is taken in a later cycle once no directory message is present.

Each processor request that is taken produces a one-cycle `cpu_done_o` pulse on the next cycle, with its result.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and not busy. `cpu_done_o`, `dreq_valid_o` and `snp_valid_o` are low, and a read to any index misses.
- R2: Processor op encoding is 0 read, 1 write, 2 evict, 3 read-shared, 4 read-exclusive, and state encoding is 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified. A request taken at an edge gives `cpu_done_o` high for one cycle after that edge. For a read, `cpu_ok_o` is 1 and `cpu_rdata_o` is the stored word only when the indexed line is not Invalid and its tag equals the address; otherwise `cpu_ok_o` is 0.
- R3: A write succeeds (`cpu_ok_o`=1) only when the line is Exclusive or Modified with a matching tag. It stores the word and makes the line Modified. Otherwise it fails and changes nothing.
- R4: An evict is accepted only when the line is not Invalid and not busy. Acceptance sets busy and issues request kind 0 carrying the line's tag as address and its word as data.
- R5: A read-shared is accepted only when the line is Invalid and not busy. It issues kind 1 with the request address.
- R6: A read-exclusive is accepted only when the line is not busy and is either Invalid or Shared with a matching tag. It issues kind 2 with the request address.
- R7: Directory message encoding is 0 fill, 1 evict-ack, 2 no-op, 3 ownership snoop, 4 sharer snoop. A fill to an Invalid line loads the tag, the word and the given state. A fill to a Shared line keeps its tag and word and only takes the new state. Both clear busy.
- R8: An evict-ack makes the line Invalid and clears busy.
- R9: A no-op clears busy and leaves the line unchanged.
- R10: An ownership snoop to an Exclusive or Modified line with a matching tag gives `snp_valid_o` for one cycle with the line's word, and moves the line to the state given (Shared or Invalid).
- R11: A sharer snoop to a Shared line with a matching tag makes it Invalid.
- R12: In a cycle with `dir_valid_i` high, no processor request is taken: `cpu_done_o` is low on the next cycle.
- R13: An issued request holds `dreq_valid_o` and its fields until `dreq_ready_i` is sampled high. While a request is pending, every transaction request is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_valid_i | input | 1 | Processor request present |
| cpu_op_i | input | 3 | Processor operation code |
| cpu_addr_i | input | ADDR_W | Request address |
| cpu_wdata_i | input | DATA_W | Write word |
| cpu_done_o | output | 1 | Request completed this cycle |
| cpu_ok_o | output | 1 | Hit, write success or transaction accepted |
| cpu_rdata_o | output | DATA_W | Read word |
| dreq_valid_o | output | 1 | Directory request pending |
| dreq_ready_i | input | 1 | Directory takes the request |
| dreq_kind_o | output | 2 | Request kind |
| dreq_addr_o | output | ADDR_W | Request address |
| dreq_data_o | output | DATA_W | Write-back word for evictions |
| dir_valid_i | input | 1 | Directory message present |
| dir_kind_i | input | 3 | Directory message code |
| dir_addr_i | input | ADDR_W | Message address |
| dir_data_i | input | DATA_W | Fill word |
| dir_state_i | input | 2 | New state for fills and ownership snoops |
| snp_valid_o | output | 1 | Snoop data returned |
| snp_data_o | output | DATA_W | Snooped word |

## Verification
The hardest situation to reach is a read-exclusive upgrade of a Shared line. In that case the fill's data must be dropped in favour of the word already held. The stimulus reaches it in steps: a read-shared, a Shared fill, an upgrade request, then an Exclusive fill that carries a different word. A follow-up read shows the old word. Two more cases need an exact cycle arrangement. One is a collision between a processor read and a fill to the same line. The other is a stalled directory channel, created by holding `dreq_ready_i` low while a second transaction is attempted.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;
  typedef enum logic [2:0] {
    OP_READ = 3'd0, OP_WRITE = 3'd1, OP_EVICT = 3'd2, OP_GETS = 3'd3, OP_GETX = 3'd4
  } cpu_op_e;
  typedef enum logic [2:0] {
    DM_FILL = 3'd0, DM_EVACK = 3'd1, DM_NOP = 3'd2, DM_SNPX = 3'd3, DM_SNPS = 3'd4
  } dir_msg_e;
  typedef enum logic [1:0] {RQ_EVICT = 2'd0, RQ_GETS = 2'd1, RQ_GETX = 2'd2} req_e;
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  mesi_e             wr_state_i,
  input  logic              busy_set_i,
  input  logic              busy_clr_i,
  input  logic [IDX_W-1:0]  busy_idx_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic [ADDR_W-1:0] a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  output mesi_e             a_state_o,
  output logic              a_busy_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic [ADDR_W-1:0] b_tag_o,
  output logic [DATA_W-1:0] b_data_o,
  output mesi_e             b_state_o,
  output logic [LINES-1:0]  busy_vec_o
);
  logic [ADDR_W-1:0] tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  mesi_e             st_q   [LINES];
  logic [LINES-1:0]  busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LINES; k++) begin
        tag_q[k]  <= '0;
        data_q[k] <= '0;
        st_q[k]   <= ST_I;
      end
      busy_q <= '0;
    end else begin
      for (int k = 0; k < LINES; k++) begin
        if (wr_en_i && wr_idx_i == IDX_W'(k)) begin
          tag_q[k]  <= wr_tag_i;
          data_q[k] <= wr_data_i;
          st_q[k]   <= wr_state_i;
        end
        if (busy_set_i && busy_idx_i == IDX_W'(k))      busy_q[k] <= 1'b1;
        else if (busy_clr_i && busy_idx_i == IDX_W'(k)) busy_q[k] <= 1'b0;
      end
    end
  end

  assign a_tag_o    = tag_q[a_idx_i];
  assign a_data_o   = data_q[a_idx_i];
  assign a_state_o  = st_q[a_idx_i];
  assign a_busy_o   = busy_q[a_idx_i];
  assign b_tag_o    = tag_q[b_idx_i];
  assign b_data_o   = data_q[b_idx_i];
  assign b_state_o  = st_q[b_idx_i];
  assign busy_vec_o = busy_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line_chk
    // Modified is only entered from Exclusive (R3)
    p_mod_from_own_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[g] == ST_M && $past(st_q[g]) != ST_M) |-> $past(st_q[g]) == ST_E);
    // leaving Invalid is a fill that ends an outstanding transaction (R7)
    p_fill_ends_txn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[g] != ST_I && $past(st_q[g]) == ST_I) |-> ($past(busy_q[g]) && !busy_q[g]));
  end
endmodule

// File: rtl/mesi_cpu_eval.sv
module mesi_cpu_eval import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  cpu_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] tag_i,
  input  logic [DATA_W-1:0] data_i,
  input  mesi_e             state_i,
  input  logic              busy_i,
  input  logic              pending_i,
  output logic              ok_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output mesi_e             wr_state_o,
  output logic              req_fire_o,
  output req_e              req_kind_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_data_o
);
  logic tag_hit, free;
  assign tag_hit = (tag_i == addr_i);
  assign free    = !busy_i && !pending_i;

  always_comb begin
    ok_o       = 1'b0;
    wr_en_o    = 1'b0;
    wr_data_o  = wdata_i;
    wr_state_o = ST_M;
    req_fire_o = 1'b0;
    req_kind_o = RQ_GETS;
    req_addr_o = addr_i;
    req_data_o = '0;
    unique case (op_i)
      OP_READ:  ok_o = (state_i != ST_I) && tag_hit;
      OP_WRITE: begin
        ok_o    = (state_i == ST_E || state_i == ST_M) && tag_hit;
        wr_en_o = ok_o;
      end
      OP_EVICT: begin
        ok_o       = (state_i != ST_I) && free;
        req_kind_o = RQ_EVICT;
        req_addr_o = tag_i;
        req_data_o = data_i;
        req_fire_o = ok_o;
      end
      OP_GETS: begin
        ok_o       = (state_i == ST_I) && free;
        req_fire_o = ok_o;
      end
      OP_GETX: begin
        ok_o       = (state_i == ST_I || (state_i == ST_S && tag_hit)) && free;
        req_kind_o = RQ_GETX;
        req_fire_o = ok_o;
      end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mesi_dir_eval.sv
module mesi_dir_eval import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  dir_msg_e          kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  mesi_e             new_state_i,
  input  logic [ADDR_W-1:0] tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  mesi_e             state_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_tag_o,
  output logic [DATA_W-1:0] wr_data_o,
  output mesi_e             wr_state_o,
  output logic              busy_clr_o,
  output logic              snp_fire_o
);
  logic tag_hit;
  assign tag_hit = (tag_i == addr_i);

  always_comb begin
    wr_en_o    = 1'b0;
    wr_tag_o   = tag_i;
    wr_data_o  = line_data_i;
    wr_state_o = state_i;
    busy_clr_o = 1'b0;
    snp_fire_o = 1'b0;
    unique case (kind_i)
      DM_FILL: begin
        wr_en_o    = 1'b1;
        busy_clr_o = 1'b1;
        wr_state_o = new_state_i;
        if (state_i == ST_I) begin
          wr_tag_o  = addr_i;
          wr_data_o = data_i;
        end
      end
      DM_EVACK: begin
        wr_en_o    = 1'b1;
        busy_clr_o = 1'b1;
        wr_state_o = ST_I;
      end
      DM_NOP: busy_clr_o = 1'b1;
      DM_SNPX: if ((state_i == ST_E || state_i == ST_M) && tag_hit) begin
        wr_en_o    = 1'b1;
        wr_state_o = new_state_i;
        snp_fire_o = 1'b1;
      end
      DM_SNPS: if (state_i == ST_S && tag_hit) begin
        wr_en_o    = 1'b1;
        wr_state_o = ST_I;
      end
      default: wr_en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic [2:0]        cpu_op_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic              cpu_ok_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              dreq_valid_o,
  input  logic              dreq_ready_i,
  output logic [1:0]        dreq_kind_o,
  output logic [ADDR_W-1:0] dreq_addr_o,
  output logic [DATA_W-1:0] dreq_data_o,
  input  logic              dir_valid_i,
  input  logic [2:0]        dir_kind_i,
  input  logic [ADDR_W-1:0] dir_addr_i,
  input  logic [DATA_W-1:0] dir_data_i,
  input  logic [1:0]        dir_state_i,
  output logic              snp_valid_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int LINES = 1 << IDX_W;

  logic [IDX_W-1:0]  c_idx, d_idx;
  logic [ADDR_W-1:0] c_tag, d_tag;
  logic [DATA_W-1:0] c_data, d_data;
  mesi_e             c_state, d_state;
  logic              c_busy;
  logic [LINES-1:0]  busy_vec;

  logic              c_ok, c_wr_en, c_fire;
  logic [DATA_W-1:0] c_wr_data, c_req_data;
  mesi_e             c_wr_state;
  req_e              c_req_kind;
  logic [ADDR_W-1:0] c_req_addr;

  logic              d_wr_en, d_busy_clr, d_snp;
  logic [ADDR_W-1:0] d_wr_tag;
  logic [DATA_W-1:0] d_wr_data;
  mesi_e             d_wr_state;

  logic              cpu_take;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] wr_tag;
  logic [DATA_W-1:0] wr_data;
  mesi_e             wr_state;

  logic              done_q, ok_q, dreq_v_q, snp_v_q;
  logic [DATA_W-1:0] rdata_q, dreq_d_q, snp_d_q;
  logic [1:0]        dreq_k_q;
  logic [ADDR_W-1:0] dreq_a_q;

  assign c_idx    = cpu_addr_i[IDX_W-1:0];
  assign d_idx    = dir_addr_i[IDX_W-1:0];
  assign cpu_take = cpu_valid_i && !dir_valid_i;

  mesi_line_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag), .wr_data_i(wr_data),
    .wr_state_i(wr_state),
    .busy_set_i(cpu_take && c_fire), .busy_clr_i(dir_valid_i && d_busy_clr),
    .busy_idx_i(dir_valid_i ? d_idx : c_idx),
    .a_idx_i(c_idx), .a_tag_o(c_tag), .a_data_o(c_data), .a_state_o(c_state),
    .a_busy_o(c_busy),
    .b_idx_i(d_idx), .b_tag_o(d_tag), .b_data_o(d_data), .b_state_o(d_state),
    .busy_vec_o(busy_vec)
  );

  mesi_cpu_eval #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cpu (
    .op_i(cpu_op_e'(cpu_op_i)), .addr_i(cpu_addr_i), .wdata_i(cpu_wdata_i),
    .tag_i(c_tag), .data_i(c_data), .state_i(c_state), .busy_i(c_busy),
    .pending_i(dreq_v_q),
    .ok_o(c_ok), .wr_en_o(c_wr_en), .wr_data_o(c_wr_data), .wr_state_o(c_wr_state),
    .req_fire_o(c_fire), .req_kind_o(c_req_kind), .req_addr_o(c_req_addr),
    .req_data_o(c_req_data)
  );

  mesi_dir_eval #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dir (
    .kind_i(dir_msg_e'(dir_kind_i)), .addr_i(dir_addr_i), .data_i(dir_data_i),
    .new_state_i(mesi_e'(dir_state_i)),
    .tag_i(d_tag), .line_data_i(d_data), .state_i(d_state),
    .wr_en_o(d_wr_en), .wr_tag_o(d_wr_tag), .wr_data_o(d_wr_data),
    .wr_state_o(d_wr_state), .busy_clr_o(d_busy_clr), .snp_fire_o(d_snp)
  );

  // directory message owns the write port when present
  always_comb begin
    if (dir_valid_i) begin
      wr_en    = d_wr_en;
      wr_idx   = d_idx;
      wr_tag   = d_wr_tag;
      wr_data  = d_wr_data;
      wr_state = d_wr_state;
    end else begin
      wr_en    = cpu_take && c_wr_en;
      wr_idx   = c_idx;
      wr_tag   = c_tag;
      wr_data  = c_wr_data;
      wr_state = c_wr_state;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      rdata_q  <= '0;
      dreq_v_q <= 1'b0;
      dreq_k_q <= '0;
      dreq_a_q <= '0;
      dreq_d_q <= '0;
      snp_v_q  <= 1'b0;
      snp_d_q  <= '0;
    end else begin
      done_q  <= cpu_take;
      ok_q    <= cpu_take && c_ok;
      rdata_q <= c_data;
      if (cpu_take && c_fire) begin
        dreq_v_q <= 1'b1;
        dreq_k_q <= c_req_kind;
        dreq_a_q <= c_req_addr;
        dreq_d_q <= c_req_data;
      end else if (dreq_ready_i) begin
        dreq_v_q <= 1'b0;
      end
      snp_v_q <= dir_valid_i && d_snp;
      snp_d_q <= d_data;
    end
  end

  assign cpu_done_o   = done_q;
  assign cpu_ok_o     = ok_q;
  assign cpu_rdata_o  = rdata_q;
  assign dreq_valid_o = dreq_v_q;
  assign dreq_kind_o  = dreq_k_q;
  assign dreq_addr_o  = dreq_a_q;
  assign dreq_data_o  = dreq_d_q;
  assign snp_valid_o  = snp_v_q;
  assign snp_data_o   = snp_d_q;

  p_dir_first_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_valid_i |=> !cpu_done_o);
  p_req_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dreq_valid_o && !dreq_ready_i) |=>
      (dreq_valid_o && $stable(dreq_addr_o) && $stable(dreq_kind_o) && $stable(dreq_data_o)));
  p_req_locks_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dreq_valid_o) |-> busy_vec[dreq_addr_o[IDX_W-1:0]]);
  p_snoop_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_o |-> $past(dir_valid_i));
endmodule

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic [2:0]  cpu_op = '0;
  logic [7:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_done, cpu_ok;
  logic [15:0] cpu_rdata;
  logic        dreq_valid;
  logic        dreq_ready = 1'b1;
  logic [1:0]  dreq_kind;
  logic [7:0]  dreq_addr;
  logic [15:0] dreq_data;
  logic        dir_valid = 1'b0;
  logic [2:0]  dir_kind = '0;
  logic [7:0]  dir_addr = '0;
  logic [15:0] dir_data = '0;
  logic [1:0]  dir_state = '0;
  logic        snp_valid;
  logic [15:0] snp_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mesi_line_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_valid_i(cpu_valid), .cpu_op_i(cpu_op), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_done_o(cpu_done), .cpu_ok_o(cpu_ok),
    .cpu_rdata_o(cpu_rdata),
    .dreq_valid_o(dreq_valid), .dreq_ready_i(dreq_ready), .dreq_kind_o(dreq_kind),
    .dreq_addr_o(dreq_addr), .dreq_data_o(dreq_data),
    .dir_valid_i(dir_valid), .dir_kind_i(dir_kind), .dir_addr_i(dir_addr),
    .dir_data_i(dir_data), .dir_state_i(dir_state),
    .snp_valid_o(snp_valid), .snp_data_o(snp_data)
  );

  task automatic check(input bit good, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  // {dir, op/kind, addr, data, state, exp_ok, exp_data, req}
  // evict rows carry the expected request address in data[7:0]
  localparam int NV = 37;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0,3'd0,8'h05,16'h0000,2'd0,1'b0,16'h0000,4'd2},  // R2 cold miss
    {1'b0,3'd1,8'h05,16'h1111,2'd0,1'b0,16'h0000,4'd3},  // R3 write to Invalid
    {1'b0,3'd2,8'h05,16'h0000,2'd0,1'b0,16'h0000,4'd4},  // R4 evict Invalid
    {1'b0,3'd3,8'h05,16'h0000,2'd0,1'b1,16'h0000,4'd5},  // R5 accepted
    {1'b0,3'd3,8'h05,16'h0000,2'd0,1'b0,16'h0000,4'd5},  // R5 busy
    {1'b0,3'd4,8'h05,16'h0000,2'd0,1'b0,16'h0000,4'd6},  // R6 busy
    {1'b1,3'd0,8'h05,16'h1234,2'd1,1'b0,16'h0000,4'd7},  // R7 fill Shared
    {1'b0,3'd0,8'h05,16'h0000,2'd0,1'b1,16'h1234,4'd2},  // R2 hit
    {1'b0,3'd0,8'h09,16'h0000,2'd0,1'b0,16'h0000,4'd2},  // R2 tag mismatch
    {1'b0,3'd1,8'h05,16'h2222,2'd0,1'b0,16'h0000,4'd3},  // R3 write Shared
    {1'b0,3'd3,8'h05,16'h0000,2'd0,1'b0,16'h0000,4'd5},  // R5 not Invalid
    {1'b0,3'd4,8'h09,16'h0000,2'd0,1'b0,16'h0000,4'd6},  // R6 Shared other tag
    {1'b0,3'd4,8'h05,16'h0000,2'd0,1'b1,16'h0000,4'd6},  // R6 upgrade
    {1'b1,3'd0,8'h05,16'hDEAD,2'd2,1'b0,16'h0000,4'd7},  // R7 upgrade fill
    {1'b0,3'd0,8'h05,16'h0000,2'd0,1'b1,16'h1234,4'd7},  // R7 data kept
    {1'b0,3'd1,8'h05,16'h5555,2'd0,1'b1,16'h0000,4'd3},  // R3 write Exclusive
    {1'b0,3'd0,8'h05,16'h0000,2'd0,1'b1,16'h5555,4'd3},  // R3 stored
    {1'b1,3'd3,8'h05,16'h0000,2'd1,1'b0,16'h5555,4'd10}, // R10 to Shared
    {1'b0,3'd0,8'h05,16'h0000,2'd0,1'b1,16'h5555,4'd10}, // R10 still readable
    {1'b0,3'd1,8'h05,16'h6666,2'd0,1'b0,16'h0000,4'd10}, // R10 no longer owned
    {1'b1,3'd4,8'h05,16'h0000,2'd0,1'b0,16'h0000,4'd11}, // R11 invalidate
    {1'b0,3'd0,8'h05,16'h0000,2'd0,1'b0,16'h0000,4'd11}, // R11 miss
    {1'b0,3'd4,8'h0A,16'h0000,2'd0,1'b1,16'h0000,4'd6},  // R6 from Invalid
    {1'b1,3'd0,8'h0A,16'h0BEE,2'd2,1'b0,16'h0000,4'd7},  // R7 fill Exclusive
    {1'b0,3'd1,8'h0A,16'h7777,2'd0,1'b1,16'h0000,4'd3},  // R3
    {1'b0,3'd2,8'h02,16'h000A,2'd0,1'b1,16'h7777,4'd4},  // R4 evict by index
    {1'b0,3'd2,8'h0A,16'h000A,2'd0,1'b0,16'h0000,4'd4},  // R4 busy
    {1'b1,3'd1,8'h0A,16'h0000,2'd0,1'b0,16'h0000,4'd8},  // R8 evict ack
    {1'b0,3'd0,8'h0A,16'h0000,2'd0,1'b0,16'h0000,4'd8},  // R8 miss
    {1'b0,3'd3,8'h0A,16'h0000,2'd0,1'b1,16'h0000,4'd8},  // R8 busy cleared
    {1'b1,3'd2,8'h0A,16'h0000,2'd0,1'b0,16'h0000,4'd9},  // R9 no-op
    {1'b0,3'd3,8'h0A,16'h0000,2'd0,1'b1,16'h0000,4'd9},  // R9 still Invalid, free
    {1'b1,3'd2,8'h0A,16'h0000,2'd0,1'b0,16'h0000,4'd9},  // R9
    {1'b0,3'd4,8'h03,16'h0000,2'd0,1'b1,16'h0000,4'd6},  // R6
    {1'b1,3'd0,8'h03,16'h0042,2'd2,1'b0,16'h0000,4'd7},  // R7
    {1'b1,3'd3,8'h03,16'h0000,2'd0,1'b0,16'h0042,4'd10}, // R10 to Invalid
    {1'b0,3'd0,8'h03,16'h0000,2'd0,1'b0,16'h0000,4'd10}  // R10 miss
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!cpu_done && !dreq_valid && !snp_valid, 1, {cpu_done, dreq_valid, snp_valid}, 0); // R1
    rst_n = 1'b1;
    @(negedge clk);
    check(!cpu_done && !dreq_valid && !snp_valid, 1, {cpu_done, dreq_valid, snp_valid}, 0); // R1
    for (int a = 0; a < 4; a++) begin
      cpu_valid = 1'b1; cpu_op = 3'd0; cpu_addr = 8'(a);
      @(negedge clk);
      cpu_valid = 1'b0;
      check(cpu_done && !cpu_ok, 1, {cpu_done, cpu_ok}, 32'h2); // R1 reset lines miss
    end

    for (int i = 0; i < NV; i++) begin
      logic        is_dir, eok;
      logic [2:0]  op;
      logic [7:0]  ad;
      logic [15:0] dt, ed;
      logic [1:0]  st;
      int          rq;
      is_dir = VEC[i][50]; op = VEC[i][49:47]; ad = VEC[i][46:39]; dt = VEC[i][38:23];
      st = VEC[i][22:21]; eok = VEC[i][20]; ed = VEC[i][19:4]; rq = int'(VEC[i][3:0]);
      if (is_dir) begin
        dir_valid = 1'b1; dir_kind = op; dir_addr = ad; dir_data = dt; dir_state = st;
      end else begin
        cpu_valid = 1'b1; cpu_op = op; cpu_addr = ad; cpu_wdata = dt;
      end
      @(negedge clk);
      dir_valid = 1'b0;
      cpu_valid = 1'b0;
      if (is_dir) begin
        check(!cpu_done, rq, cpu_done, 0);
        check(snp_valid == (op == 3'd3), rq, snp_valid, (op == 3'd3));
        if (op == 3'd3) check(snp_data == ed, rq, snp_data, ed);
      end else begin
        check(cpu_done && cpu_ok == eok, rq, {cpu_done, cpu_ok}, {1'b1, eok});
        if (op == 3'd0 && eok) check(cpu_rdata == ed, rq, cpu_rdata, ed);
        if (op >= 3'd2) begin
          check(dreq_valid == eok, rq, dreq_valid, eok);
          if (eok) begin
            logic [1:0] ek;
            logic [7:0] ea;
            ek = (op == 3'd2) ? 2'd0 : (op == 3'd3) ? 2'd1 : 2'd2;
            ea = (op == 3'd2) ? dt[7:0] : ad;
            check(dreq_kind == ek && dreq_addr == ea, rq, {dreq_kind, dreq_addr}, {ek, ea});
            if (op == 3'd2) check(dreq_data == ed, rq, dreq_data, ed);
          end
        end
      end
    end

    // R12: fill and read collide on one line; the read waits and sees the fill
    cpu_valid = 1'b1; cpu_op = 3'd3; cpu_addr = 8'h07;
    @(negedge clk);
    check(cpu_done && cpu_ok, 5, {cpu_done, cpu_ok}, 32'h3);
    cpu_op = 3'd0;
    dir_valid = 1'b1; dir_kind = 3'd0; dir_addr = 8'h07; dir_data = 16'h0099; dir_state = 2'd1;
    @(negedge clk);
    dir_valid = 1'b0;
    check(!cpu_done, 12, cpu_done, 0);
    @(negedge clk);
    cpu_valid = 1'b0;
    check(cpu_done && cpu_ok && cpu_rdata == 16'h0099, 12, {cpu_done, cpu_ok, cpu_rdata},
          {2'b11, 16'h0099});

    // R13: stalled directory channel
    dreq_ready = 1'b0;
    cpu_valid = 1'b1; cpu_op = 3'd4; cpu_addr = 8'h04;
    @(negedge clk);
    check(cpu_ok && dreq_valid, 13, {cpu_ok, dreq_valid}, 32'h3);
    cpu_op = 3'd3; cpu_addr = 8'h01;
    @(negedge clk);
    cpu_valid = 1'b0;
    check(cpu_done && !cpu_ok, 13, {cpu_done, cpu_ok}, 32'h2);
    check(dreq_valid && dreq_kind == 2'd2 && dreq_addr == 8'h04, 13,
          {dreq_valid, dreq_kind, dreq_addr}, {1'b1, 2'd2, 8'h04});
    dreq_ready = 1'b1;
    @(negedge clk);
    check(!dreq_valid, 13, dreq_valid, 0);
    cpu_valid = 1'b1; cpu_op = 3'd3; cpu_addr = 8'h01;
    @(negedge clk);
    cpu_valid = 1'b0;
    check(cpu_ok && dreq_valid && dreq_addr == 8'h01, 13, {cpu_ok, dreq_valid, dreq_addr},
          {2'b11, 8'h01});

    summary();
  end
endmodule